// File: doc/BRIEF.md
# 32-bit Arithmetic and Logic Unit with Operation Decoder

This block is the execute-stage arithmetic unit of a simple load/store processor core. It combines two pieces of pure combinational logic. The first is an operation decoder. It takes the two-bit instruction class from the main control and the six-bit function field of a register-format instruction, and turns them into a four-bit operation code. The second is a 32-bit datapath. It applies that operation to two operands and produces a result word and a zero flag.

Memory instructions always need an address sum, so they select addition. Branch-on-equal selects subtraction and takes its decision from the zero flag. Register-format instructions select their operation from the function field. The operation code also appears on an output port, so the surrounding datapath can observe it. Nothing in the block is clocked: every output settles from the current inputs.

Top module: `alu32_top`

## Requirements
- R1: Operation code 4'b0000 drives the result with the bitwise AND of the two operands.
- R2: Operation code 4'b0001 drives the result with the bitwise OR of the two operands.
- R3: Operation code 4'b0010 drives the result with the operand sum, truncated to 32 bits (wraps modulo 2^32).
- R4: Operation code 4'b0110 drives the result with operand A minus operand B, truncated to 32 bits.
- R5: Operation code 4'b0111 gives 1 in bit 0 when A is less than B as signed two's-complement values, and 0 otherwise. Bits 31..1 are always zero. The comparison is correct even when A minus B overflows.
- R6: Operation code 4'b1100 drives the result with the bitwise NOR of the two operands.
- R7: The decoder emits 4'b1111 for class 2'b11, and for class 2'b10 with a function field outside the six listed in R11. Any operation code outside the six above yields a result of zero.
- R8: The zero flag is 1 exactly when all 32 result bits are 0.
- R9: Class 2'b00 (load/store) selects operation 4'b0010 whatever the function field holds.
- R10: Class 2'b01 (branch-equal) selects operation 4'b0110 whatever the function field holds.
- R11: Class 2'b10 decodes the function field as follows: 6'h20 gives 4'b0010, 6'h22 gives 4'b0110, 6'h24 gives 4'b0000, 6'h25 gives 4'b0001, 6'h2A gives 4'b0111, and 6'h27 gives 4'b1100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_class | input | 2 | Instruction class from main control (00 memory, 01 branch, 10 register-format, 11 reserved) |
| funct | input | 6 | Function field of a register-format instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_op | output | 4 | Decoded operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when the result is all zeros |

## Verification
The embedded immediate assertions take the inputs to be fully known two-state values. They also expect to be evaluated only once the combinational logic has settled. A transient or undefined operand would break that assumption. The bench drives every input field completely on the falling clock edge and reads the outputs several nanoseconds later. It steers the operation only through legal class and function values, and reaches the reserved codes through class 11 and an unlisted function field.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned CLS_W   = 2;
  localparam int unsigned FUNCT_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_SUB  = 4'b0110,
    OP_SLT  = 4'b0111,
    OP_NOR  = 4'b1100,
    OP_NONE = 4'b1111
  } alu_op_e;

  typedef enum logic [CLS_W-1:0] {
    CLS_MEM    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_RTYPE  = 2'b10,
    CLS_RSVD   = 2'b11
  } alu_cls_e;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUNCT_W-1:0] FN_NOR = 6'h27;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/alu32_ctrl_dec.sv
module alu32_ctrl_dec
  import alu32_pkg::*;
(
  input  logic [CLS_W-1:0]   cls_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output alu_op_e            op_o
);

  alu_op_e fn_op;

  // Register-format function field lookup
  always_comb begin
    case (funct_i)
      FN_ADD:  fn_op = OP_ADD;
      FN_SUB:  fn_op = OP_SUB;
      FN_AND:  fn_op = OP_AND;
      FN_OR:   fn_op = OP_OR;
      FN_SLT:  fn_op = OP_SLT;
      FN_NOR:  fn_op = OP_NOR;
      default: fn_op = OP_NONE;
    endcase
  end

  // Class selection
  always_comb begin
    case (alu_cls_e'(cls_i))
      CLS_MEM:    op_o = OP_ADD;
      CLS_BRANCH: op_o = OP_SUB;
      CLS_RTYPE:  op_o = fn_op;
      default:    op_o = OP_NONE;
    endcase
  end

  always_comb begin
    if (cls_i == CLS_MEM)
      AST_MEM_ADD: assert (op_o == OP_ADD) else $error("memory class not add"); // R9
    if (cls_i == CLS_BRANCH)
      AST_BR_SUB: assert (op_o == OP_SUB) else $error("branch class not sub"); // R10
    if (cls_i == CLS_RSVD)
      AST_RSVD_NONE: assert (op_o == OP_NONE) else $error("reserved class decoded"); // R7
  end

endmodule

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         less_o
);

  logic [W-1:0] b_eff;
  logic         ovf;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    sum_o  = a_i + b_eff + W'(sub_i);
    ovf    = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
    less_o = sum_o[W-1] ^ ovf;
  end

  always_comb begin
    if (sub_i && (a_i == b_i))
      AST_EQ_DIFF_ZERO: assert (sum_o == '0) else $error("equal operands nonzero difference"); // R4
    if (sub_i && (a_i == b_i))
      AST_EQ_NOT_LESS: assert (!less_o) else $error("equal operands reported less"); // R5
  end

endmodule

// File: rtl/alu32_logic.sv
module alu32_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] nor_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_o[i] = a_i[i] & b_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
    assign nor_o[i] = ~(a_i[i] | b_i[i]);
  end

endmodule

// File: rtl/alu32_top.sv
module alu32_top
  import alu32_pkg::*;
(
  input  logic [CLS_W-1:0]   alu_class,
  input  logic [FUNCT_W-1:0] funct,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  output logic [OP_W-1:0]    alu_op,
  output logic [DATA_W-1:0]  result,
  output logic               zero
);

  alu_op_e           op_sel;
  logic              do_sub;
  logic [DATA_W-1:0] arith_v;
  logic              less_v;
  logic [DATA_W-1:0] and_v;
  logic [DATA_W-1:0] or_v;
  logic [DATA_W-1:0] nor_v;

  alu32_ctrl_dec u_dec (
    .cls_i   (alu_class),
    .funct_i (funct),
    .op_o    (op_sel)
  );

  assign do_sub = (op_sel == OP_SUB) || (op_sel == OP_SLT);

  alu32_addsub #(.W(DATA_W)) u_addsub (
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .sub_i  (do_sub),
    .sum_o  (arith_v),
    .less_o (less_v)
  );

  alu32_logic #(.W(DATA_W)) u_logic (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .and_o (and_v),
    .or_o  (or_v),
    .nor_o (nor_v)
  );

  always_comb begin
    case (op_sel)
      OP_AND:  result = and_v;
      OP_OR:   result = or_v;
      OP_ADD:  result = arith_v;
      OP_SUB:  result = arith_v;
      OP_SLT:  result = {{(DATA_W-1){1'b0}}, less_v};
      OP_NOR:  result = nor_v;
      default: result = '0;
    endcase
  end

  assign zero   = ~|result;
  assign alu_op = op_sel;

  always_comb begin
    if (op_sel == OP_SLT)
      AST_SLT_UPPER: assert (result[DATA_W-1:1] == '0) else $error("slt upper bits set"); // R5
    if (op_sel == OP_NONE)
      AST_UNUSED_ZERO: assert (result == '0 && zero) else $error("unused code nonzero"); // R7
    if (op_sel == OP_SUB && opnd_a == opnd_b)
      AST_SUB_EQ_FLAG: assert (zero) else $error("equal subtract without zero flag"); // R8
    if (op_sel == OP_OR && (opnd_a != '0 || opnd_b != '0))
      AST_OR_NONZERO: assert (!zero) else $error("or of nonzero gave zero flag"); // R2
  end

endmodule

// File: tb/tb_alu32_top.sv
module tb_alu32_top;

  logic        clk;
  logic        rst_n;
  logic [1:0]  alu_class;
  logic [5:0]  funct;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [3:0]  alu_op;
  logic [31:0] result;
  logic        zero;

  int n_chk;
  int n_bad;
  bit done;

  alu32_top dut (
    .alu_class (alu_class),
    .funct     (funct),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .alu_op    (alu_op),
    .result    (result),
    .zero      (zero)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [3:0] ref_op(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return 4'b0010;
    if (c == 2'b01) return 4'b0110;
    if (c == 2'b11) return 4'b1111;
    case (f)
      6'h20: return 4'b0010;
      6'h22: return 4'b0110;
      6'h24: return 4'b0000;
      6'h25: return 4'b0001;
      6'h2A: return 4'b0111;
      6'h27: return 4'b1100;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] ref_res(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    case (o)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return a + b;
      4'b0110: return a - b;
      4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'b1100: return ~(a | b);
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [5:0] f,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    alu_class = c;
    funct     = f;
    opnd_a    = a;
    opnd_b    = b;
    #5;
  endtask

  // Full check of op, result and zero flag
  task automatic run(input string req, input logic [1:0] c, input logic [5:0] f,
                     input logic [31:0] a, input logic [31:0] b);
    logic [3:0]  eo;
    logic [31:0] er;
    apply(c, f, a, b);
    eo = ref_op(c, f);
    er = ref_res(eo, a, b);
    chk(req, {28'd0, alu_op}, {28'd0, eo});
    chk(req, result, er);
    chk({req, "/R8"}, {31'd0, zero}, {31'd0, (er == 32'd0)});
  endtask

  task automatic t_idle;
    apply(2'b10, 6'h24, 32'd0, 32'd0);
    chk("R1 idle", result, 32'd0);
    chk("R8 idle", {31'd0, zero}, 32'd1);
  endtask

  task automatic t_logic;
    run("R1", 2'b10, 6'h24, 32'hF0F0_1234, 32'h0FF0_FF00);
    run("R1", 2'b10, 6'h24, 32'hAAAA_AAAA, 32'h5555_5555);
    run("R2", 2'b10, 6'h25, 32'hF000_0000, 32'h0000_000F);
    run("R2", 2'b10, 6'h25, 32'h0, 32'h0);
    run("R6", 2'b10, 6'h27, 32'h0, 32'h0);
    run("R6", 2'b10, 6'h27, 32'hFFFF_0000, 32'h0000_FFFF);
  endtask

  task automatic t_arith;
    run("R3", 2'b10, 6'h20, 32'd1234, 32'd4321);
    run("R3 wrap", 2'b10, 6'h20, 32'hFFFF_FFFF, 32'd1);
    run("R4", 2'b10, 6'h22, 32'd100, 32'd58);
    run("R4 borrow", 2'b10, 6'h22, 32'd0, 32'd1);
    run("R4 equal", 2'b10, 6'h22, 32'h1357_9BDF, 32'h1357_9BDF);
  endtask

  task automatic t_slt;
    run("R5 lt", 2'b10, 6'h2A, 32'd3, 32'd9);
    run("R5 ge", 2'b10, 6'h2A, 32'd9, 32'd3);
    run("R5 eq", 2'b10, 6'h2A, 32'd7, 32'd7);
    run("R5 neg", 2'b10, 6'h2A, 32'hFFFF_FFFF, 32'd0);
    run("R5 ovf", 2'b10, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF);
    run("R5 ovf2", 2'b10, 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000);
  endtask

  task automatic t_classes;
    run("R9", 2'b00, 6'h22, 32'h0000_1000, 32'hFFFF_FFFC);
    run("R9", 2'b00, 6'h3F, 32'd5, 32'd6);
    run("R10", 2'b01, 6'h24, 32'd42, 32'd42);
    run("R10", 2'b01, 6'h20, 32'd42, 32'd41);
  endtask

  task automatic t_unused;
    run("R7 rsvd", 2'b11, 6'h20, 32'hDEAD_BEEF, 32'h1);
    run("R7 funct", 2'b10, 6'h00, 32'hDEAD_BEEF, 32'h1);
    run("R7 funct", 2'b10, 6'h26, 32'h1234_5678, 32'h8765_4321);
  endtask

  task automatic t_funct_sweep;
    for (int i = 0; i < 64; i++) begin
      apply(2'b10, 6'(i), 32'hC3A5_0F96, 32'h5A3C_F069);
      chk("R11", {28'd0, alu_op}, {28'd0, ref_op(2'b10, 6'(i))});
      chk("R11/R7", result, ref_res(ref_op(2'b10, 6'(i)), 32'hC3A5_0F96, 32'h5A3C_F069));
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    alu_class = 2'b00; funct = 6'd0; opnd_a = 32'd0; opnd_b = 32'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_logic();
    t_arith();
    t_slt();
    t_classes();
    t_unused();
    t_funct_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule